// File: doc/BRIEF.md
# Supervisor Reset and Watchdog Controller

This block turns three asynchronous digital conditions into one active-low system reset. The conditions are a supply-good flag from an external rail comparator, an active-low manual reset pin and a processor-driven watchdog strobe. Reset is held low while the supply is bad or the manual pin is low. Once every cause has cleared, reset is released only after a fixed delay. While reset is released, the processor must toggle the strobe at least once per timeout window. If it does not, the block pulls reset low and releases it through the same delay.

The control is a three-state machine:
- `ST_HOLD`: a cause is present and reset is low.
- `ST_DELAY`: no cause is present, reset is low and the release counter is running.
- `ST_RUN`: reset is high and the watchdog is counting.

The transitions are:
- HOLD→DELAY when no cause remains.
- DELAY→RUN when the delay count completes.
- DELAY→HOLD or RUN→HOLD whenever a cause reappears.
- RUN→DELAY on a watchdog timeout.

All timing constants are parameters in clock cycles:
- `DELAY_CYC` is the release delay, 100 ms at 50 MHz by default.
- `WD_CYC` is the watchdog timeout, 0.8 s at 50 MHz by default.
- `FILT_CYC` is the glitch-filter length.

A watchdog-enable input lets a board that does not use the watchdog keep it permanently quiet.

Top module: `sup_reset_ctrl`

## Requirements
- R1: While `rst_n` is low, `rst_out_n` is low. While `supply_ok` is low, `rst_out_n` is low; a falling `supply_ok` drives `rst_out_n` low on the third clock edge after the change (two synchroniser stages plus one state update).
- R2: From power-up with all causes clear, `rst_out_n` rises exactly `DELAY_CYC`+3 clock edges after `supply_ok` rises, and the delay count starts only once the synchronised supply flag is good.
- R3: A drop of `supply_ok` during the release delay sends reset back to hold, and the delay restarts from zero. The low period is then the time from the first drop to the last rise plus `DELAY_CYC`.
- R4: A filtered low on `mr_n` forces reset low. Reset is released `DELAY_CYC` cycles after the filtered `mr_n` returns high, so a clean low pulse of P cycles gives a reset low period of exactly P+`DELAY_CYC` cycles.
- R5: Both a rising and a falling edge of the filtered `wdi` clear the watchdog counter, so strobing with one edge every `WD_CYC`/2 cycles or less keeps reset high.
- R6: In `ST_RUN` with `wd_en` high and no `wdi` edge, reset stays high for exactly `WD_CYC` cycles and then goes low.
- R7: A watchdog reset lasts exactly `DELAY_CYC` cycles and then releases.
- R8: While the synchronised `wd_en` is low, the watchdog counter is held at zero and never causes a reset.
- R9: `mr_n` and `wdi` pass a filter. A level held for fewer than `FILT_CYC` synchronised samples is ignored, and one held for `FILT_CYC` or more is accepted.
- R10: The watchdog counter is held at zero while reset is low and starts counting only when reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset of the block's own logic |
| supply_ok | input | 1 | Asynchronous flag, high when the output rail is above its threshold |
| mr_n | input | 1 | Asynchronous manual reset, active low |
| wdi | input | 1 | Asynchronous watchdog strobe; either edge services the watchdog |
| wd_en | input | 1 | Watchdog enable; low keeps the watchdog counter cleared |
| rst_out_n | output | 1 | Active-low system reset |

## Verification
The hardest case to reach from the ports is a supply drop that lands inside an already running release delay. Only the restart of the delay from zero tells a correct design from one that merely pauses the count. The stimulus removes the supply, restores it, waits ten cycles so that the machine sits in `ST_DELAY`, and then drops it again for two cycles. The expected low period is the full span from the first drop to the last rise plus the delay.

Telling the either-edge watchdog service apart from a rising-edge-only one is the second difficult case. The strobe toggles every 25 cycles against a 40-cycle timeout. This interval is safe only if both edges count.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_DELAY = 2'd1,
        ST_RUN   = 2'd2
    } sup_state_t;

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q_sync <= RST_VAL;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end
endmodule

// File: rtl/sup_filter.sv
module sup_filter #(
    parameter int           W        = 1,
    parameter int           FILT_CYC = 3,
    parameter logic [W-1:0] RST_VAL  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    localparam int FW = $clog2(FILT_CYC + 1);
    localparam logic [FW-1:0] LIM = FW'(FILT_CYC - 1);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [FW-1:0] run_cnt;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                run_cnt  <= '0;
                d_out[i] <= RST_VAL[i];
            end else if (d_in[i] == d_out[i]) begin
                run_cnt  <= '0;
            end else if (run_cnt == LIM) begin
                run_cnt  <= '0;
                d_out[i] <= d_in[i];
            end else begin
                run_cnt  <= run_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog #(
    parameter int WD_CYC = 40_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wdi_f,
    input  logic run,
    input  logic en,
    output logic trip,
    output logic edge_o,
    output logic zero_o
);
    localparam int WW = $clog2(WD_CYC + 1);
    localparam logic [WW-1:0] LIM = WW'(WD_CYC - 1);

    logic          wdi_q;
    logic [WW-1:0] cnt;

    assign edge_o = wdi_f ^ wdi_q;
    assign zero_o = (cnt == '0);
    assign trip   = run && en && !edge_o && (cnt == LIM);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wdi_q <= 1'b0;
            cnt   <= '0;
        end else begin
            wdi_q <= wdi_f;
            if (!run || !en || edge_o) begin
                cnt <= '0;
            end else if (cnt != LIM) begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl
    import sup_pkg::*;
#(
    parameter int DELAY_CYC = 5_000_000,
    parameter int WD_CYC    = 40_000_000,
    parameter int FILT_CYC  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic mr_n,
    input  logic wdi,
    input  logic wd_en,
    output logic rst_out_n
);
    localparam int DW = $clog2(DELAY_CYC + 1);
    localparam logic [DW-1:0] DLIM = DW'(DELAY_CYC - 1);

    logic [3:0] raw_s;
    logic       sup_s, mr_s, wdi_s, wd_en_s;
    logic [1:0] filt_q;
    logic       mr_f, wdi_f;
    logic       wd_trip, wd_edge, wd_zero;
    logic       cause;

    sup_state_t    state, nxt;
    logic [DW-1:0] dly_cnt;

    sup_sync #(.W(4), .RST_VAL(4'b0010)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_async({wd_en, wdi, mr_n, supply_ok}),
        .q_sync(raw_s)
    );
    assign sup_s   = raw_s[0];
    assign mr_s    = raw_s[1];
    assign wdi_s   = raw_s[2];
    assign wd_en_s = raw_s[3];

    sup_filter #(.W(2), .FILT_CYC(FILT_CYC), .RST_VAL(2'b01)) u_filt (
        .clk(clk), .rst_n(rst_n),
        .d_in({wdi_s, mr_s}),
        .d_out(filt_q)
    );
    assign mr_f  = filt_q[0];
    assign wdi_f = filt_q[1];

    sup_wdog #(.WD_CYC(WD_CYC)) u_wdog (
        .clk(clk), .rst_n(rst_n),
        .wdi_f(wdi_f),
        .run(state == ST_RUN),
        .en(wd_en_s),
        .trip(wd_trip),
        .edge_o(wd_edge),
        .zero_o(wd_zero)
    );

    assign cause = !sup_s || !mr_f;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_HOLD:  if (!cause) nxt = ST_DELAY;
            ST_DELAY: begin
                if (cause)                nxt = ST_HOLD;
                else if (dly_cnt == DLIM) nxt = ST_RUN;
            end
            ST_RUN: begin
                if (cause)        nxt = ST_HOLD;
                else if (wd_trip) nxt = ST_DELAY;
            end
            default:              nxt = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_HOLD;
            dly_cnt <= '0;
        end else begin
            state   <= nxt;
            dly_cnt <= (state == ST_DELAY) ? dly_cnt + 1'b1 : '0;
        end
    end

    always_comb begin
        rst_out_n = (state == ST_RUN);
    end
endmodule

// File: rtl/sup_reset_ctrl_chk.sv
module sup_reset_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic sup_s,
    input logic mr_f,
    input logic wd_en_s,
    input logic wd_trip,
    input logic wd_edge,
    input logic wd_zero,
    input logic rst_out_n
);
    AST_SUPPLY_LOW: assert property (@(posedge clk) disable iff (!rst_n) !sup_s |=> !rst_out_n); // R1
    AST_RELEASE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_out_n) |-> $past(sup_s && mr_f)); // R2
    AST_MANUAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !mr_f |=> !rst_out_n); // R4
    AST_EDGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) wd_edge |=> wd_zero); // R5
    AST_TRIP_DROPS: assert property (@(posedge clk) disable iff (!rst_n) (wd_trip && rst_out_n && sup_s && mr_f) |=> !rst_out_n); // R6
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !wd_en_s |-> !wd_trip); // R8
    AST_WD_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) !rst_out_n |=> wd_zero); // R10
endmodule

bind sup_reset_ctrl sup_reset_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sup_s(sup_s), .mr_f(mr_f),
    .wd_en_s(wd_en_s), .wd_trip(wd_trip), .wd_edge(wd_edge),
    .wd_zero(wd_zero), .rst_out_n(rst_out_n)
);

// File: tb/sup_reset_ctrl_test.sv
module sup_reset_ctrl_test;
    localparam int DLY = 20;
    localparam int WD  = 40;
    localparam int FLT = 3;

    logic clk = 1'b0;
    logic rst_n, supply_ok, mr_n, wdi, wd_en;
    logic rst_out_n;

    always #10 clk = ~clk;

    sup_reset_ctrl #(.DELAY_CYC(DLY), .WD_CYC(WD), .FILT_CYC(FLT)) uut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .mr_n(mr_n),
        .wdi(wdi), .wd_en(wd_en), .rst_out_n(rst_out_n)
    );

    typedef struct {
        bit    lvl;
        int    len;
        string tag;
    } run_t;

    run_t expq[$];
    int   checks = 0;
    int   errors = 0;
    bit   mon_on = 0;
    bit   done   = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic push_run(input bit l, input int n, input string t);
        run_t r;
        r.lvl = l; r.len = n; r.tag = t;
        expq.push_back(r);
    endtask

    task automatic wait_level(input bit l);
        while (rst_out_n !== l) @(negedge clk);
    endtask

    // monitor: measures each completed level run of the reset output
    bit cur_lvl = 1'b0;
    int cur_len = 0;
    always @(negedge clk) begin
        if (mon_on) begin
            if (rst_out_n === cur_lvl) begin
                cur_len++;
            end else begin
                if (expq.size() == 0) begin
                    check(1'b0, "unexpected reset transition", cur_len, -1);
                end else begin
                    run_t r;
                    r = expq.pop_front();
                    check(r.lvl == cur_lvl && (r.len < 0 || r.len == cur_len),
                          r.tag, cur_len, r.len);
                end
                cur_lvl = rst_out_n;
                cur_len = 1;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        int lows;
        rst_n = 0; supply_ok = 0; mr_n = 1; wdi = 0; wd_en = 1;
        repeat (4) @(negedge clk);
        check(rst_out_n == 1'b0, "R1 reset state", rst_out_n, 0);
        rst_n = 1;
        mon_on = 1;
        push_run(0, -1, "R2 power-up low");
        push_run(1, WD, "R6 R10 timeout window");
        push_run(0, DLY, "R7 watchdog reset length");
        repeat (10) @(negedge clk);
        check(rst_out_n == 1'b0, "R1 supply low holds reset", rst_out_n, 0);

        // R2: release latency from supply good
        supply_ok = 1;
        n = 0;
        while (rst_out_n !== 1'b1) begin
            @(negedge clk);
            n++;
        end
        check(n == DLY + 3, "R2 release latency", n, DLY + 3);

        // R6/R7 run through the monitor; then R5 strobe servicing
        wait_level(0);
        wait_level(1);
        push_run(1, -1, "R5 R8 serviced high");
        push_run(0, DLY, "R7 second watchdog reset");
        lows = 0;
        for (int k = 0; k < 10; k++) begin
            for (int c = 0; c < 25; c++) begin
                @(negedge clk);
                if (!rst_out_n) lows++;
            end
            wdi = ~wdi;
        end
        check(lows == 0, "R5 both edges service", lows, 0);

        // R8: disabled watchdog never trips
        wd_en = 0;
        lows = 0;
        for (int c = 0; c < 150; c++) begin
            @(negedge clk);
            if (!rst_out_n) lows++;
        end
        check(lows == 0, "R8 disabled watchdog quiet", lows, 0);
        wd_en = 1;
        wait_level(0);
        wait_level(1);
        wd_en = 0;

        // R9: short manual glitch ignored
        push_run(1, -1, "R9 high before manual reset");
        repeat (5) @(negedge clk);
        mr_n = 0;
        repeat (FLT - 1) @(negedge clk);
        mr_n = 1;
        lows = 0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (!rst_out_n) lows++;
        end
        check(lows == 0, "R9 glitch ignored", lows, 0);

        // R4: manual reset pulse of 5 cycles
        push_run(0, 5 + DLY, "R4 manual reset low period");
        mr_n = 0;
        repeat (5) @(negedge clk);
        mr_n = 1;
        wait_level(0);
        wait_level(1);

        // R1/R3: supply drop latency and delay restart
        push_run(1, -1, "R3 high before supply drop");
        push_run(0, 16 + DLY, "R3 delay restart");
        repeat (5) @(negedge clk);
        supply_ok = 0;
        repeat (2) @(negedge clk);
        check(rst_out_n == 1'b1, "R1 not yet low after two edges", rst_out_n, 1);
        @(negedge clk);
        check(rst_out_n == 1'b0, "R1 low on third edge", rst_out_n, 0);
        @(negedge clk);
        supply_ok = 1;
        repeat (10) @(negedge clk);
        supply_ok = 0;
        repeat (2) @(negedge clk);
        supply_ok = 1;
        wait_level(1);
        repeat (5) @(negedge clk);

        check(expq.size() == 0, "R3 all expected runs seen", expq.size(), 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule